// File: doc/BRIEF.md
# Four-Bank Interleaved Block Refill Controller

This block fetches one four-word cache block from a main memory built as four one-word-wide banks, with word `n` held in bank `n mod 4`. A refill request carries a word address. The controller keeps only the block part of that address. It spends a fixed address phase sending the row to every bank at once, and then lets all four banks run their long access in parallel. It captures the four words in one cycle and then returns them one at a time over a single one-word response stream. The slow bank access is paid once per block and not once per word. With the default timing of 4 address cycles, 56 access cycles and 4 cycles per transfer, a block costs 4 + 56 + 4×4 = 76 cycles.

Both the request side and the response side are valid/ready streams. On the request side, a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. On the response side, a word moves on an edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the current word, its last flag and `rsp_valid` all stay unchanged. The transfer time for the next word only starts after the current word has been accepted, so each stall cycle adds exactly one cycle to the block. The bank ports are plain control pins. There is one start strobe per bank and one shared row, and each bank drives its data back on its own slice of `bank_rdata`.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and every `bank_start` bit is 0.
- R2: From the edge that accepts a request until the edge that accepts its fourth word, `req_ready` is 0, and a `req_valid` held high in that window starts nothing. In the cycle after the fourth word is accepted, `req_ready` is 1 again.
- R3: The two low bits of `req_addr` are ignored. `bank_row` equals `req_addr[ADDR_W-1:2]`. All four `bank_start` bits rise together for exactly one cycle, which is the ADDR_CYC-th cycle after the accepting edge (cycle 4 by default).
- R4: Each bank's slice of `bank_rdata` (bank b at bits `[b*DATA_W +: DATA_W]`) is sampled only on the edge ACC_CYC cycles after its start cycle. Later changes on that slice do not alter the returned words.
- R5: Words come back in ascending bank order 0, 1, 2, 3, which is ascending word address from the block base. `rsp_last` is 1 with the fourth word and 0 with the others.
- R6: With `rsp_ready` held high, the first word is accepted ADDR_CYC+ACC_CYC+XFER_CYC cycles (64) after the request edge. Each later word follows XFER_CYC cycles after the one before it, so the last word is accepted 76 cycles after the request edge.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_last` hold steady. Each stall cycle delays that word and every later word of the block by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Word address inside the wanted block |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Consumer takes the word |
| rsp_data | output | DATA_W | Returned word |
| rsp_last | output | 1 | Marks the fourth word of the block |
| bank_start | output | NBANK | One-cycle access strobe per bank |
| bank_row | output | ADDR_W-2 | Row sent to every bank |
| bank_rdata | input | NBANK*DATA_W | Bank read data, one slice per bank |

## Verification
The assertions assume that `rsp_ready` is a clean 0/1 level and that the consumer keeps no hidden limit on stalls. They also assume that each bank presents its word on the sampling edge the controller expects, ACC_CYC cycles after its strobe. The bench's bank models drive the correct word only in that one cycle and drive its inverse at every other time. This keeps the stimulus inside the timing assumption and makes any early or late sampling visible. Requests are held high back to back so that the controller must refuse them while busy. The consumer either stays ready or follows a fixed stall pattern that never holds `rsp_ready` low for ever.

// File: rtl/ilv_refill_pkg.sv
package ilv_refill_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_ACCESS = 2'd2,
    PH_XFER   = 2'd3
  } refill_phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/ilv_phase_timer.sv
module ilv_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ilv_bank_capture.sv
module ilv_bank_capture #(
  parameter int DATA_W    = 64,
  parameter int NBANK     = 4,
  parameter int BANK_BITS = 2
) (
  input  logic                    clk,
  input  logic                    capture,
  input  logic [NBANK*DATA_W-1:0] bank_rdata,
  input  logic [BANK_BITS-1:0]    sel,
  output logic [DATA_W-1:0]       word
);

  logic [DATA_W-1:0] word_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (capture) word_q[b] <= bank_rdata[b*DATA_W +: DATA_W];
    end
  end

  assign word = word_q[sel];

endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl
  import ilv_refill_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 32,
  parameter int NBANK    = 4,
  parameter int ADDR_CYC = 4,
  parameter int ACC_CYC  = 56,
  parameter int XFER_CYC = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [DATA_W-1:0]             rsp_data,
  output logic                          rsp_last,
  output logic [NBANK-1:0]              bank_start,
  output logic [ADDR_W-$clog2(NBANK)-1:0] bank_row,
  input  logic [NBANK*DATA_W-1:0]       bank_rdata
);

  localparam int BANK_BITS = $clog2(NBANK);
  localparam int ROW_W     = ADDR_W - BANK_BITS;
  localparam int MAX_CYC   = max3(ADDR_CYC, ACC_CYC, XFER_CYC);
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  refill_phase_e         phase_q;
  logic [BANK_BITS-1:0]  word_idx_q;
  logic [ROW_W-1:0]      row_q;
  logic                  start_q;
  logic                  expired;
  logic                  timer_load;
  logic [CNT_W-1:0]      timer_val;
  logic                  accept, capture, rsp_fire, last_word, addr_done;
  logic                  unused_low_bits;

  assign unused_low_bits = ^req_addr[BANK_BITS-1:0];

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign addr_done = (phase_q == PH_ADDR) && expired;
  assign capture   = (phase_q == PH_ACCESS) && expired;
  assign rsp_valid = (phase_q == PH_XFER) && expired;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign last_word = (word_idx_q == BANK_BITS'(NBANK - 1));
  assign rsp_last  = rsp_valid && last_word;

  // Reload the phase timer at each phase boundary and at each word slot.
  always_comb begin
    timer_load = 1'b0;
    timer_val  = '0;
    if (accept) begin
      timer_load = 1'b1;
      timer_val  = CNT_W'(ADDR_CYC - 1);
    end else if (addr_done) begin
      timer_load = 1'b1;
      timer_val  = CNT_W'(ACC_CYC - 1);
    end else if (capture || (rsp_fire && !last_word)) begin
      timer_load = 1'b1;
      timer_val  = CNT_W'(XFER_CYC - 1);
    end
  end

  ilv_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      word_idx_q <= '0;
      row_q      <= '0;
      start_q    <= 1'b0;
    end else begin
      start_q <= addr_done;
      case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_ADDR;
          row_q   <= req_addr[ADDR_W-1:BANK_BITS];
        end
        PH_ADDR:   if (addr_done) phase_q <= PH_ACCESS;
        PH_ACCESS: if (capture) begin
          phase_q    <= PH_XFER;
          word_idx_q <= '0;
        end
        PH_XFER: if (rsp_fire) begin
          if (last_word) phase_q <= PH_IDLE;
          else           word_idx_q <= word_idx_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign bank_start = {NBANK{start_q}};
  assign bank_row   = row_q;

  ilv_bank_capture #(
    .DATA_W    (DATA_W),
    .NBANK     (NBANK),
    .BANK_BITS (BANK_BITS)
  ) u_capture (
    .clk        (clk),
    .capture    (capture),
    .bank_rdata (bank_rdata),
    .sel        (word_idx_q),
    .word       (rsp_data)
  );

  // R2: a refill in flight refuses new requests.
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  p_no_ready_while_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R3: all banks start together, for a single cycle.
  p_start_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_start) |-> (&bank_start));
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_start) |=> !(|bank_start));
  // R5: the last flag only rides on a valid word.
  p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);
  // R7: a stalled word is held unchanged.
  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

endmodule

// File: tb/ilv_refill_ctrl_bench.sv
module ilv_refill_ctrl_bench;

  localparam int DATA_W = 64;
  localparam int ADDR_W = 32;
  localparam int NBANK  = 4;
  localparam int ACC    = 56;
  localparam int ROW_W  = ADDR_W - 2;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    req_valid = 1'b0;
  logic                    req_ready;
  logic [ADDR_W-1:0]       req_addr = '0;
  logic                    rsp_valid;
  logic                    rsp_ready = 1'b1;
  logic [DATA_W-1:0]       rsp_data;
  logic                    rsp_last;
  logic [NBANK-1:0]        bank_start;
  logic [ROW_W-1:0]        bank_row;
  logic [NBANK*DATA_W-1:0] bank_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit bp_mode = 1'b0;
  bit done    = 1'b0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc++;

  ilv_refill_ctrl u_ilv_refill_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .bank_start(bank_start), .bank_row(bank_row), .bank_rdata(bank_rdata)
  );

  function automatic logic [63:0] word_val(input logic [31:0] a);
    return {a ^ 32'hA5A5_0F0F, a * 32'h9E37_79B9};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bank models: correct word only in the single cycle before the sampling edge.
  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    int               cnt;
    logic             vld;
    logic [ROW_W-1:0] row;
    always @(posedge clk) begin
      if (!rst_n) begin
        cnt <= 0; vld <= 1'b0; row <= '0;
      end else if (bank_start[gb]) begin
        cnt <= ACC - 2; vld <= 1'b0; row <= bank_row;
      end else if (cnt == 1) begin
        vld <= 1'b1; cnt <= 0;
      end else begin
        vld <= 1'b0;
        if (cnt > 1) cnt <= cnt - 1;
      end
    end
    assign bank_rdata[gb*DATA_W +: DATA_W] =
      vld ? word_val({row, 2'(gb)}) : ~word_val({row, 2'(gb)});
  end

  always @(posedge clk) rsp_ready <= bp_mode ? ((cyc % 3) != 1) : 1'b1;

  // Scoreboard queues
  logic [63:0]      exp_q[$];
  bit               exp_last_q[$];
  int               acc_q[$];
  logic [ROW_W-1:0] row_q[$];

  task automatic do_refill(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    acc_q.push_back(cyc + 1);
    row_q.push_back(a[31:2]);
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(word_val({a[31:2], 2'(k)}));
      exp_last_q.push_back(k == 3);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor
  int          widx = 0;
  int          stall_blk = 0;
  bit          hold_prev = 1'b0;
  logic [63:0] hold_data;
  bit          ready_next = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ready_next) begin
        check(req_ready == 1'b1, "R2 ready after last", 64'(req_ready), 64'd1);
        ready_next = 1'b0;
      end
      if (hold_prev) begin
        check(rsp_valid && rsp_data == hold_data, "R7 hold", rsp_data, hold_data);
        hold_prev = 1'b0;
      end
      if (|bank_start && acc_q.size() > 0) begin
        check(bank_start == 4'hF, "R3 start together", 64'(bank_start), 64'hF);
        check(cyc == acc_q[0] + 4, "R3 start cycle", 64'(cyc - acc_q[0]), 64'd4);
        check(bank_row == row_q[0], "R3 row", 64'(bank_row), 64'(row_q[0]));
      end
      if (rsp_valid && !rsp_ready) begin
        stall_blk++;
        hold_prev = 1'b1;
        hold_data = rsp_data;
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected word", rsp_data, 64'd0);
        end else begin
          logic [63:0] e;
          bit          el;
          e  = exp_q.pop_front();
          el = exp_last_q.pop_front();
          check(rsp_data == e, "R4 data", rsp_data, e);
          check(rsp_last == el, "R5 last", 64'(rsp_last), 64'(el));
          check(req_ready == 1'b0, "R2 busy", 64'(req_ready), 64'd0);
          if (widx == 0)
            check(cyc + 1 - acc_q[0] == 64 + stall_blk, "R6 first word",
                  64'(cyc + 1 - acc_q[0]), 64'(64 + stall_blk));
          widx++;
          if (el) begin
            int lat;
            lat = cyc + 1 - acc_q.pop_front();
            void'(row_q.pop_front());
            check(lat == 76 + stall_blk, bp_mode ? "R7 latency" : "R6 latency",
                  64'(lat), 64'(76 + stall_blk));
            widx = 0;
            stall_blk = 0;
            ready_next = 1'b1;
          end
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R1 valid", 64'(rsp_valid), 64'd0);
    check(bank_start == '0, "R1 start", 64'(bank_start), 64'd0);

    do_refill(32'h0000_0000);
    do_refill(32'h0000_0005);        // R3 low bits ignored
    do_refill(32'hFFFF_FFFE);
    do_refill(32'h1234_5678);
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);

    bp_mode = 1'b1;                  // R7 back-pressure
    do_refill(32'h0BAD_F00B);
    do_refill(32'h7654_3210);
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule